// File: doc/BRIEF.md
# Skewed Three-Bank Branch Direction Predictor

This block predicts the direction of conditional branches. It keeps three equal banks of 2-bit saturating counters. Each bank is indexed by its own mix of the branch address and a global outcome history. A lookup reads one counter from each bank and returns the majority of their upper bits as the predicted direction. Because the three index functions differ, two branches that share a counter in one bank usually land on separate counters in the other two. The vote therefore tends to outvote a single aliased bank, which gives some of the benefit of associativity without storing tags.

A lookup is a valid/ready request carrying the branch address. The answer comes back one cycle later on a valid/ready response channel, together with the history value that was used to form it. The pipeline holds the history value until the branch resolves. The resolve channel then returns the address, the real outcome and that saved history. The block rebuilds the three indices from these values and reads the three banks' current opinions. It then trains the counters: every bank is trained when the vote was wrong, and only the banks that agreed with the outcome are trained when the vote was right. After training, the outcome is shifted into the global history.

Back-pressure: the response register is the only buffer. A new lookup is accepted when the response slot is empty or is being drained in the same cycle. While a response is held (`lr_valid` high, `lr_ready` low), the response does not change and `lk_ready` stays low. The resolve channel never stalls.

Top module: `skew_vote_bp`

## Requirements
- R1: While reset is asserted, and right after it is released, `lr_valid` is 0. Every counter holds 2'b01 (weakly not-taken). The global history is zero, so the first lookup predicts not-taken and returns history 0.
- R2: A lookup accepted on a clock edge produces a response (`lr_valid`=1) after that edge. `lr_taken` is 1 when at least two of the three addressed counters have their MSB set.
- R3: The address slice S is the XOR-fold of the address into IDX_W bits: address bit i goes to slice bit i mod IDX_W. With history H, the bank indices are: bank 0 uses H^S; bank 1 uses H rotated left by one bit, XOR S; bank 2 uses H bit-reversed, XOR S.
- R4: Each counter saturates. A taken outcome raises it by one, up to 3, and a not-taken outcome lowers it by one, down to 0. A counter votes taken when its MSB is 1.
- R5: When the vote formed at resolve time differs from the outcome, all three addressed counters are trained toward the outcome.
- R6: When the vote formed at resolve time equals the outcome, only the banks whose own MSB equals the outcome are trained. A dissenting bank's counter is left unchanged.
- R7: The resolve indices come from `rs_pc` and `rs_hist`, not from the live history. On each resolve the live history shifts left by one, with `rs_taken` entering at bit 0. `lr_hist` returns the live history as it was when the lookup was accepted.
- R8: `lk_ready` equals `!lr_valid || lr_ready`. While `lr_valid` is 1 and `lr_ready` is 0, `lr_taken` and `lr_hist` hold their values.
- R9: `rs_ready` is always 1. A lookup accepted in the same cycle as a resolve sees the counters and history from before that resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted |
| lk_pc | input | PC_W | Branch address for the lookup (offset bits already stripped) |
| lr_valid | output | 1 | Lookup response valid |
| lr_ready | input | 1 | Consumer takes the response |
| lr_taken | output | 1 | Predicted direction (1 = taken) |
| lr_hist | output | IDX_W | History used by this prediction, to be returned on resolve |
| rs_valid | input | 1 | Resolve request valid |
| rs_ready | output | 1 | Resolve accepted (constant 1) |
| rs_pc | input | PC_W | Branch address being resolved |
| rs_taken | input | 1 | Actual outcome |
| rs_hist | input | IDX_W | History captured at lookup time |

## Verification
The bench drives both saturation ends: three taken outcomes followed by decrements, and a counter pushed below zero. A design whose counters wrap flips direction at the limits. It builds a bank-0-only collision that leaves one bank dissenting under a correct vote. It then steers the history to a palindromic value so that this bank decides a later vote. A design that trained the dissenter, or that trained nobody after a miss, predicts the wrong way there. Other tests cover a held response under back-pressure and a lookup in the same cycle as a resolve on the same entry; a design that forwarded the new counter would return the updated vote. A long mixed run checks every response against a reference model, including the returned history.

// File: rtl/skew_bp_pkg.sv
package skew_bp_pkg;

  localparam int NUM_BANKS = 3;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'b01;

  typedef enum logic [1:0] {
    HASH_XOR = 2'd0,
    HASH_ROT = 2'd1,
    HASH_REV = 2'd2
  } hash_kind_e;

  function automatic ctr_t ctr_step(ctr_t c, logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

endpackage

// File: rtl/skew_bp_fold.sv
module skew_bp_fold #(
  parameter int PC_W  = 14,
  parameter int IDX_W = 6
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] slice
);
  localparam int NCH = (PC_W + IDX_W - 1) / IDX_W;

  logic [NCH*IDX_W-1:0] pad;
  logic [IDX_W-1:0]     acc;

  always_comb begin
    pad = '0;
    pad[PC_W-1:0] = pc;
    acc = '0;
    for (int c = 0; c < NCH; c++) acc = acc ^ pad[c*IDX_W +: IDX_W];
  end

  assign slice = acc;
endmodule

// File: rtl/skew_bp_hash.sv
module skew_bp_hash
  import skew_bp_pkg::*;
#(
  parameter int         W    = 6,
  parameter hash_kind_e KIND = HASH_XOR
) (
  input  logic [W-1:0] hist,
  input  logic [W-1:0] slice,
  output logic [W-1:0] idx
);
  logic [W-1:0] mix;

  if (KIND == HASH_XOR) begin : g_xor
    assign mix = hist;
  end else if (KIND == HASH_ROT) begin : g_rot
    assign mix = {hist[W-2:0], hist[W-1]};
  end else begin : g_rev
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign mix[i] = hist[W-1-i];
    end
  end

  assign idx = mix ^ slice;
endmodule

// File: rtl/skew_bp_bank.sv
module skew_bp_bank
  import skew_bp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output ctr_t             rd_a_ctr,
  input  logic [IDX_W-1:0] rd_b_idx,
  output ctr_t             rd_b_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ctr_t             wr_ctr
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_ctr;
    end
  end

  assign rd_a_ctr = mem[rd_a_idx];
  assign rd_b_ctr = mem[rd_b_idx];
endmodule

// File: rtl/skew_bp_upd.sv
module skew_bp_upd
  import skew_bp_pkg::*;
#(
  parameter int NB = 3
) (
  input  logic                valid,
  input  logic                taken,
  input  logic [NB-1:0][1:0]  ctr,
  output logic [NB-1:0]       bank_pred,
  output logic [NB-1:0]       wr_en,
  output logic [NB-1:0][1:0]  wr_ctr
);
  logic vote;
  logic mispred;

  for (genvar b = 0; b < NB; b++) begin : g_pred
    assign bank_pred[b] = ctr[b][1];
  end

  assign vote    = ($countones(bank_pred) > NB / 2);
  assign mispred = (vote != taken);

  for (genvar b = 0; b < NB; b++) begin : g_wr
    assign wr_en[b]  = valid && (mispred || (bank_pred[b] == taken));
    assign wr_ctr[b] = ctr_step(ctr[b], taken);
  end
endmodule

// File: rtl/skew_vote_bp.sv
module skew_vote_bp
  import skew_bp_pkg::*;
#(
  parameter int PC_W  = 14,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             lr_valid,
  input  logic             lr_ready,
  output logic             lr_taken,
  output logic [IDX_W-1:0] lr_hist,
  input  logic             rs_valid,
  output logic             rs_ready,
  input  logic [PC_W-1:0]  rs_pc,
  input  logic             rs_taken,
  input  logic [IDX_W-1:0] rs_hist
);
  localparam int HIST_W = IDX_W;

  logic [HIST_W-1:0]                ghr;
  logic [IDX_W-1:0]                 lk_slice;
  logic [IDX_W-1:0]                 rs_slice;
  logic [NUM_BANKS-1:0][IDX_W-1:0]  lk_idx;
  logic [NUM_BANKS-1:0][IDX_W-1:0]  rs_idx;
  logic [NUM_BANKS-1:0][1:0]        lk_ctr;
  logic [NUM_BANKS-1:0][1:0]        rs_ctr;
  logic [NUM_BANKS-1:0][1:0]        wr_ctr;
  logic [NUM_BANKS-1:0]             lk_msb;
  logic [NUM_BANKS-1:0]             rs_bank_pred;
  logic [NUM_BANKS-1:0]             wr_en;
  logic                             lk_vote;
  logic                             lk_fire;

  skew_bp_fold #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_fold (.pc(lk_pc), .slice(lk_slice));
  skew_bp_fold #(.PC_W(PC_W), .IDX_W(IDX_W)) u_rs_fold (.pc(rs_pc), .slice(rs_slice));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam hash_kind_e KIND = hash_kind_e'(b);

    skew_bp_hash #(.W(IDX_W), .KIND(KIND)) u_lk_hash (
      .hist  (ghr),
      .slice (lk_slice),
      .idx   (lk_idx[b])
    );

    skew_bp_hash #(.W(IDX_W), .KIND(KIND)) u_rs_hash (
      .hist  (rs_hist),
      .slice (rs_slice),
      .idx   (rs_idx[b])
    );

    skew_bp_bank #(.IDX_W(IDX_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_a_idx (lk_idx[b]),
      .rd_a_ctr (lk_ctr[b]),
      .rd_b_idx (rs_idx[b]),
      .rd_b_ctr (rs_ctr[b]),
      .wr_en    (wr_en[b]),
      .wr_idx   (rs_idx[b]),
      .wr_ctr   (wr_ctr[b])
    );

    assign lk_msb[b] = lk_ctr[b][1];
  end

  skew_bp_upd #(.NB(NUM_BANKS)) u_upd (
    .valid     (rs_valid),
    .taken     (rs_taken),
    .ctr       (rs_ctr),
    .bank_pred (rs_bank_pred),
    .wr_en     (wr_en),
    .wr_ctr    (wr_ctr)
  );

  assign lk_vote  = ($countones(lk_msb) > NUM_BANKS / 2);
  assign lk_ready = !lr_valid || lr_ready;
  assign lk_fire  = lk_valid && lk_ready;
  assign rs_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_valid <= 1'b0;
      lr_taken <= 1'b0;
      lr_hist  <= '0;
    end else if (lk_fire) begin
      lr_valid <= 1'b1;
      lr_taken <= lk_vote;
      lr_hist  <= ghr;
    end else if (lr_ready) begin
      lr_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ghr <= '0;
    else if (rs_valid) ghr <= {ghr[HIST_W-2:0], rs_taken};
  end
endmodule

// File: rtl/skew_bp_chk.sv
module skew_bp_chk #(
  parameter int IDX_W = 6,
  parameter int NB    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic             lr_valid,
  input logic             lr_ready,
  input logic             lr_taken,
  input logic [IDX_W-1:0] lr_hist,
  input logic [IDX_W-1:0] ghr,
  input logic             rs_valid,
  input logic             rs_taken,
  input logic [NB-1:0]    rs_bank_pred,
  input logic [NB-1:0]    wr_en
);
  // R2: an accepted lookup yields a response on the next cycle
  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> lr_valid)
    else $error("a_r2_resp_follows");

  // R8: a stalled response holds its contents
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_valid && !lr_ready) |=> (lr_valid && $stable(lr_taken) && $stable(lr_hist)))
    else $error("a_r8_hold_stable");

  // R8: no new lookup is taken while a response is stalled
  a_r8_block_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_valid && !lr_ready) |-> !lk_ready)
    else $error("a_r8_block_lookup");

  // R7: history shifts the outcome in on each resolve
  a_r7_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> (ghr == {$past(ghr[IDX_W-2:0]), $past(rs_taken)}))
    else $error("a_r7_hist_shift");

  // R7: history is frozen without a resolve
  a_r7_hist_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> $stable(ghr))
    else $error("a_r7_hist_idle");

  // R5: a wrong vote trains every bank
  a_r5_all_trained: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && (($countones(rs_bank_pred) > NB / 2) != rs_taken)) |-> (&wr_en))
    else $error("a_r5_all_trained");

  for (genvar b = 0; b < NB; b++) begin : g_bank_chk
    // R6: a dissenting bank stays untouched on a right vote
    a_r6_dissent_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && (($countones(rs_bank_pred) > NB / 2) == rs_taken)
                && (rs_bank_pred[b] != rs_taken)) |-> !wr_en[b])
      else $error("a_r6_dissent_kept");

    // R6: an agreeing bank is always trained
    a_r6_agree_trained: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && (rs_bank_pred[b] == rs_taken)) |-> wr_en[b])
      else $error("a_r6_agree_trained");

    // R9: counters never change without a resolve
    a_r9_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
      !rs_valid |-> !wr_en[b])
      else $error("a_r9_no_stray_write");
  end
endmodule

bind skew_vote_bp skew_bp_chk #(.IDX_W(IDX_W), .NB(skew_bp_pkg::NUM_BANKS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_valid     (lk_valid),
  .lk_ready     (lk_ready),
  .lr_valid     (lr_valid),
  .lr_ready     (lr_ready),
  .lr_taken     (lr_taken),
  .lr_hist      (lr_hist),
  .ghr          (ghr),
  .rs_valid     (rs_valid),
  .rs_taken     (rs_taken),
  .rs_bank_pred (rs_bank_pred),
  .wr_en        (wr_en)
);

// File: tb/test_skew_vote_bp.sv
module test_skew_vote_bp;
  localparam int PC_W       = 14;
  localparam int IDX_W      = 6;
  localparam int NB         = 3;
  localparam int DEPTH      = 1 << IDX_W;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             lk_valid = 1'b0;
  logic             lk_ready;
  logic [PC_W-1:0]  lk_pc = '0;
  logic             lr_valid;
  logic             lr_ready = 1'b1;
  logic             lr_taken;
  logic [IDX_W-1:0] lr_hist;
  logic             rs_valid = 1'b0;
  logic             rs_ready;
  logic [PC_W-1:0]  rs_pc = '0;
  logic             rs_taken = 1'b0;
  logic [IDX_W-1:0] rs_hist = '0;

  skew_vote_bp #(.PC_W(PC_W), .IDX_W(IDX_W)) i_skew_vote_bp (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc),
    .lr_valid(lr_valid), .lr_ready(lr_ready), .lr_taken(lr_taken), .lr_hist(lr_hist),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_pc(rs_pc),
    .rs_taken(rs_taken), .rs_hist(rs_hist)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // reference model
  logic [1:0]       mdl [NB][DEPTH];
  logic [IDX_W-1:0] mghr;
  int n_chk = 0;
  int n_err = 0;

  typedef struct {
    logic             t;
    logic [IDX_W-1:0] h;
    int               tag;
  } exp_t;
  exp_t exp_q[$];
  exp_t mon_e;

  function automatic string tagname(int k);
    case (k)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(bit ok, int tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tagname(tag), what, act, exp);
    end
  endtask

  function automatic logic [IDX_W-1:0] slice_of(logic [PC_W-1:0] pc);
    logic [IDX_W-1:0] s;
    s = '0;
    for (int i = 0; i < PC_W; i++) s[i % IDX_W] = s[i % IDX_W] ^ pc[i];
    return s;
  endfunction

  function automatic logic [IDX_W-1:0] bidx(int b, logic [IDX_W-1:0] h, logic [PC_W-1:0] pc);
    logic [IDX_W-1:0] m;
    if (b == 0) m = h;
    else if (b == 1) m = {h[IDX_W-2:0], h[IDX_W-1]};
    else for (int i = 0; i < IDX_W; i++) m[i] = h[IDX_W-1-i];
    return m ^ slice_of(pc);
  endfunction

  function automatic logic m_vote(logic [PC_W-1:0] pc, logic [IDX_W-1:0] h);
    int cnt;
    cnt = 0;
    for (int b = 0; b < NB; b++) if (mdl[b][bidx(b, h, pc)][1]) cnt++;
    return cnt >= 2;
  endfunction

  task automatic m_resolve(logic [PC_W-1:0] pc, logic [IDX_W-1:0] h, logic t);
    logic v;
    logic [IDX_W-1:0] ix;
    v = m_vote(pc, h);
    for (int b = 0; b < NB; b++) begin
      ix = bidx(b, h, pc);
      if (v != t || mdl[b][ix][1] == t) begin
        if (t && mdl[b][ix] != 2'b11) mdl[b][ix] = mdl[b][ix] + 2'd1;
        else if (!t && mdl[b][ix] != 2'b00) mdl[b][ix] = mdl[b][ix] - 2'd1;
      end
    end
    mghr = {mghr[IDX_W-2:0], t};
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && lr_valid && lr_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, 2, "unexpected response", 1, 0);
      end else begin
        mon_e = exp_q.pop_front();
        check(lr_taken == mon_e.t, mon_e.tag, "direction", int'(lr_taken), int'(mon_e.t));
        check(lr_hist == mon_e.h, 7, "returned history", int'(lr_hist), int'(mon_e.h));
      end
    end
  end

  task automatic push_exp(logic [PC_W-1:0] pc, int tag);
    exp_t e;
    e.t = m_vote(pc, mghr);
    e.h = mghr;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic do_predict(logic [PC_W-1:0] pc, int tag);
    bit acc;
    @(posedge clk); #1;
    lk_valid = 1'b1;
    lk_pc = pc;
    push_exp(pc, tag);
    forever begin
      @(negedge clk) acc = lk_ready;
      @(posedge clk);
      if (acc) break;
    end
    #1 lk_valid = 1'b0;
  endtask

  task automatic do_resolve(logic [PC_W-1:0] pc, logic [IDX_W-1:0] h, logic t);
    @(posedge clk); #1;
    rs_valid = 1'b1;
    rs_pc = pc;
    rs_hist = h;
    rs_taken = t;
    @(posedge clk);
    m_resolve(pc, h, t);
    #1 rs_valid = 1'b0;
  endtask

  // filler resolves away from the tested entries, ending with history = g
  task automatic set_ghr(logic [IDX_W-1:0] g);
    for (int i = IDX_W - 1; i >= 0; i--) do_resolve(14'h0005, 6'h3F, g[i]);
  endtask

  initial begin
    logic [31:0] lf;
    logic        ta;
    logic [IDX_W-1:0] hv;
    logic [PC_W-1:0]  pa;

    for (int b = 0; b < NB; b++)
      for (int i = 0; i < DEPTH; i++) mdl[b][i] = 2'b01;
    mghr = '0;

    repeat (2) @(posedge clk);
    @(negedge clk);
    check(lr_valid == 1'b0, 1, "lr_valid in reset", int'(lr_valid), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(lr_valid == 1'b0, 1, "lr_valid after reset", int'(lr_valid), 0);
    check(lk_ready == 1'b1, 8, "lk_ready idle", int'(lk_ready), 1);
    check(rs_ready == 1'b1, 9, "rs_ready", int'(rs_ready), 1);

    // R1: fresh counters predict not-taken with zero history
    do_predict(14'h0000, 1);
    do_predict(14'h0123, 1);

    // R5: first taken outcome misses the vote, every bank trained
    do_resolve(14'h0010, 6'h00, 1'b1);
    set_ghr(6'h00);
    do_predict(14'h0010, 5);

    // R4: climb and saturate at 3, then step down
    do_resolve(14'h0010, 6'h00, 1'b1);
    do_resolve(14'h0010, 6'h00, 1'b1);
    do_resolve(14'h0010, 6'h00, 1'b0);
    set_ghr(6'h00);
    do_predict(14'h0010, 4);
    do_resolve(14'h0010, 6'h00, 1'b0);
    do_resolve(14'h0010, 6'h00, 1'b0);
    do_resolve(14'h0010, 6'h00, 1'b0);
    do_resolve(14'h0010, 6'h00, 1'b1);
    set_ghr(6'h00);
    do_predict(14'h0010, 4);
    do_resolve(14'h0010, 6'h00, 1'b1);
    set_ghr(6'h00);
    do_predict(14'h0010, 4);

    // R6: collide only in bank 0, vote is right, bank 0 dissents and is kept
    do_resolve(14'h0011, 6'h01, 1'b0);
    set_ghr(6'h21);
    do_predict(14'h0031, 6);
    // R3: same history, other address lands on differently hashed entries
    do_predict(14'h0010, 3);
    do_predict(14'h0011, 3);

    // R8: stalled response holds and blocks further lookups
    @(posedge clk); #1 lr_ready = 1'b0;
    do_predict(14'h0031, 8);
    begin
      logic st;
      logic [IDX_W-1:0] sh;
      @(posedge clk); #1;
      lk_valid = 1'b1;
      lk_pc = 14'h0010;
      push_exp(14'h0010, 8);
      @(negedge clk);
      check(lk_ready == 1'b0, 8, "lk_ready while stalled", int'(lk_ready), 0);
      check(lr_valid == 1'b1, 8, "lr_valid while stalled", int'(lr_valid), 1);
      st = lr_taken;
      sh = lr_hist;
      @(negedge clk);
      check(lk_ready == 1'b0, 8, "lk_ready still stalled", int'(lk_ready), 0);
      check(lr_taken == st, 8, "held direction", int'(lr_taken), int'(st));
      check(lr_hist == sh, 8, "held history", int'(lr_hist), int'(sh));
      @(posedge clk); #1 lr_ready = 1'b1;
      @(posedge clk); #1 lk_valid = 1'b0;
    end

    // R9: lookup and resolve on one entry in one cycle see pre-update state
    @(posedge clk); #1;
    lk_valid = 1'b1;
    lk_pc = 14'h002A;
    rs_valid = 1'b1;
    rs_pc = 14'h002A;
    rs_hist = mghr;
    rs_taken = 1'b1;
    push_exp(14'h002A, 9);
    @(posedge clk);
    m_resolve(14'h002A, rs_hist, 1'b1);
    #1;
    lk_valid = 1'b0;
    rs_valid = 1'b0;
    do_predict(14'h002A, 9);

    // mixed run against the model (R2, R3, R5, R6, R7)
    lf = 32'h1234_5679;
    for (int n = 0; n < 1500; n++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      pa = lf[19:6];
      hv = lf[5:0];
      ta = pa[0] ^ (lf[25:23] == 3'd0);
      do_resolve(pa, hv, ta);
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      do_predict(lf[PC_W-1:0], (n % 2 == 0) ? 2 : 3);
    end

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, 2, "responses still pending", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R2 watchdog expired: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule